// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction Engine

This block turns one 4x4 block of signed 16-bit transform coefficients into pixel residuals with a two-pass separable integer inverse transform. It then adds each residual to the matching unsigned 8-bit prediction pixel and delivers the reconstructed pixels clamped to 0..255. The first pass runs a fixed-point butterfly down each column. The intermediate matrix is transposed, and the same butterfly runs along each row. Every second-pass value is rounded by three bits before the prediction is added.

Coefficients enter one row of four per beat on a valid/ready port, top row first. Prediction rows enter on a second, independent valid/ready port. Reconstructed rows leave, top row first, on a valid/ready output. If the pair bit is set with the first coefficient beat, a second coefficient block follows and is reconstructed against the prediction block that sits four pixels to the right. The output tags every row with the block it belongs to.

Top module: `idct4_recon`

## Requirements
- R1: The coefficient port accepts exactly four rows per block, top row first. Coefficient index 4*row+col travels in lane col at bits [16*col+15:16*col]. Both load ports hold ready low from the moment their four rows are taken until the block's last output row has been accepted.
- R2: The prediction port accepts four rows per block, with pixel col in bits [8*col+7:8*col]. Prediction and coefficient beats may arrive in any interleaving, including all prediction rows first.
- R3: Each butterfly forms a = in0+in8 and b = in0-in8. It uses m1(x) = x + ((x*20091)>>16) and m2(x) = (x*35468)>>16, then c = m2(in4)-m1(in12) and d = m1(in4)+m2(in12), and emits a+d, b+c, b-c, a-d in that order. Every add, subtract and the m1 result saturate to the signed 16-bit range.
- R4: The first pass runs over the columns (inputs are rows 0..3 of one column). Its outputs are transposed, and the second pass runs over the rows of the intermediate result.
- R5: Each second-pass value v becomes the residual (v+4)>>3, with an arithmetic shift.
- R6: The residual is added to the zero-extended prediction pixel without any intermediate clamp. Only the sum is clamped to 0..255, so a zero residual returns the prediction unchanged.
- R7: Output rows leave top row first with pixel col in bits [8*col+7:8*col]. While out_valid_o is high and out_ready_i is low, the row data and the block tag hold steady.
- R8: pair_i is sampled only with the first coefficient beat of a block. When it is 1, a second block of four coefficient rows and four prediction rows is taken after the first block's output has drained, and its rows leave with out_blk_o = 1. Otherwise out_blk_o = 0 and the engine returns to idle.
- R9: out_valid_o rises on the third rising clock edge after the edge that accepts the last outstanding load beat of a block.
- R10: After reset, out_valid_o is low and both load ports are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_i | input | 1 | Pair-mode request, sampled with the first coefficient beat |
| coef_valid_i | input | 1 | Coefficient row valid |
| coef_ready_o | output | 1 | Coefficient row ready |
| coef_row_i | input | 4*COEF_W | Four signed coefficients of one row |
| pred_valid_i | input | 1 | Prediction row valid |
| pred_ready_o | output | 1 | Prediction row ready |
| pred_row_i | input | 4*PIX_W | Four prediction pixels of one row |
| out_valid_o | output | 1 | Reconstructed row valid |
| out_ready_i | input | 1 | Downstream ready |
| out_row_o | output | 4*PIX_W | Four reconstructed pixels of one row |
| out_blk_o | output | 1 | 0 for the first block, 1 for the right-hand block in pair mode |

## Verification
Several properties are checked on every cycle: the load ports stay closed during the passes and the output phase, the load counters never pass four rows, a stalled output row keeps its index and block tag, the second-block tag appears only when pair mode was latched, and the sequencer steps PASS1, PASS2, OUTPUT without gaps. Two combinational checks also run: a zero butterfly input gives a zero output, and a zero residual returns the prediction pixel. Arithmetic exactness can only be shown by the bench scenarios. These cover saturation on extreme coefficients, rounding, clipping at 0 and 255, the three-cycle load-to-output latency, prediction-first loading, and pair mode under random backpressure, all compared against an independent integer model.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  localparam int N       = 4;      // points per butterfly, rows per block
  localparam int K1      = 20091;  // fractional part of the first multiplier
  localparam int K2      = 35468;  // second multiplier, unsigned magnitude
  localparam int MUL_SH  = 16;     // high-half shift after multiply
  localparam int RND_SH  = 3;      // residual rounding shift

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_PASS1, S_PASS2, S_OUT, S_BLK2
  } st_e;
endpackage

// File: rtl/idct4_bfly.sv
module idct4_bfly import idct4_pkg::*; #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] i0,
  input  logic signed [W-1:0] i1,
  input  logic signed [W-1:0] i2,
  input  logic signed [W-1:0] i3,
  output logic signed [W-1:0] o0,
  output logic signed [W-1:0] o1,
  output logic signed [W-1:0] o2,
  output logic signed [W-1:0] o3
);
  localparam int XW = W + 18;
  localparam logic signed [XW-1:0] SMAX = XW'((1 << (W-1)) - 1);
  localparam logic signed [XW-1:0] SMIN = -SMAX - XW'(1);
  localparam logic signed [XW-1:0] C1   = XW'(K1);
  localparam logic signed [XW-1:0] C2   = XW'(K2);

  function automatic logic signed [XW-1:0] ext(input logic signed [W-1:0] v);
    return XW'(v);
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [XW-1:0] v);
    if (v > SMAX)      return SMAX[W-1:0];
    else if (v < SMIN) return SMIN[W-1:0];
    else               return v[W-1:0];
  endfunction

  // x + high half of x*K1, saturated (R3)
  function automatic logic signed [W-1:0] mul1(input logic signed [W-1:0] x);
    logic signed [XW-1:0] p;
    p = ext(x) * C1;
    return sat((p >>> MUL_SH) + ext(x));
  endfunction

  // high half of x*K2; magnitude always fits W bits (R3)
  function automatic logic signed [W-1:0] mul2(input logic signed [W-1:0] x);
    logic signed [XW-1:0] p;
    logic signed [XW-1:0] q;
    p = ext(x) * C2;
    q = p >>> MUL_SH;
    return q[W-1:0];
  endfunction

  logic signed [W-1:0] a, b, c, d;

  always_comb begin
    a  = sat(ext(i0) + ext(i2));
    b  = sat(ext(i0) - ext(i2));
    c  = sat(ext(mul2(i1)) - ext(mul1(i3)));
    d  = sat(ext(mul1(i1)) + ext(mul2(i3)));
    o0 = sat(ext(a) + ext(d));
    o1 = sat(ext(b) + ext(c));
    o2 = sat(ext(b) - ext(c));
    o3 = sat(ext(a) - ext(d));
  end

  // R3: an all-zero input vector must give an all-zero output vector
  always_comb begin
    if (i0 == '0 && i1 == '0 && i2 == '0 && i3 == '0)
      p_zero_in_zero_out_r3: assert (o0 == '0 && o1 == '0 && o2 == '0 && o3 == '0);
  end
endmodule

// File: rtl/idct4_recon_lane.sv
module idct4_recon_lane import idct4_pkg::*; #(
  parameter int W = 16,
  parameter int P = 8
) (
  input  logic signed [W-1:0] v,
  input  logic        [P-1:0] pred,
  output logic        [P-1:0] pix
);
  localparam int SW = W + 2;
  localparam logic signed [SW-1:0] PMAX    = SW'((1 << P) - 1);
  localparam logic signed [SW-1:0] RND_ADD = SW'(1 << (RND_SH - 1));

  logic signed [SW-1:0] rnd;
  logic signed [SW-1:0] sum;

  always_comb begin
    rnd = (SW'(v) + RND_ADD) >>> RND_SH;            // R5
    sum = rnd + $signed(SW'({1'b0, pred}));        // R6: wide add
    if (sum < 0)          pix = '0;
    else if (sum > PMAX)  pix = '1;
    else                  pix = sum[P-1:0];
  end

  // R6: a zero second-pass value leaves the prediction untouched
  always_comb begin
    if (v == '0)
      p_passthru_r6: assert (pix == pred);
  end
endmodule

// File: rtl/idct4_ctrl.sv
module idct4_ctrl import idct4_pkg::*; (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pair_i,
  input  logic                 coef_valid_i,
  input  logic                 pred_valid_i,
  input  logic                 out_ready_i,
  output logic                 coef_ready_o,
  output logic                 pred_ready_o,
  output logic                 coef_we_o,
  output logic                 pred_we_o,
  output logic [$clog2(N)-1:0] coef_idx_o,
  output logic [$clog2(N)-1:0] pred_idx_o,
  output logic [$clog2(N)-1:0] out_idx_o,
  output logic                 pass1_o,
  output logic                 pass2_o,
  output logic                 out_valid_o,
  output logic                 blk_o
);
  localparam int CNT_W = $clog2(N + 1);
  localparam int IDX_W = $clog2(N);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  st_e              st;
  logic [CNT_W-1:0] ccnt, pcnt;
  logic [IDX_W-1:0] ocnt;
  logic             pair_q, blk_q;
  logic             loading;

  assign loading      = (st == S_IDLE) || (st == S_LOAD);
  assign coef_ready_o = loading && (ccnt != FULL);
  assign pred_ready_o = loading && (pcnt != FULL);
  assign coef_we_o    = coef_valid_i && coef_ready_o;
  assign pred_we_o    = pred_valid_i && pred_ready_o;
  assign coef_idx_o   = ccnt[IDX_W-1:0];
  assign pred_idx_o   = pcnt[IDX_W-1:0];
  assign out_idx_o    = ocnt;
  assign pass1_o      = (st == S_PASS1);
  assign pass2_o      = (st == S_PASS2);
  assign out_valid_o  = (st == S_OUT);
  assign blk_o        = blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ccnt   <= '0;
      pcnt   <= '0;
      ocnt   <= '0;
      pair_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      if (coef_we_o) ccnt <= ccnt + CNT_W'(1);
      if (pred_we_o) pcnt <= pcnt + CNT_W'(1);
      if (coef_we_o && ccnt == '0 && !blk_q) pair_q <= pair_i;
      case (st)
        S_IDLE:  if (coef_we_o || pred_we_o) st <= S_LOAD;
        S_LOAD:  if (ccnt == FULL && pcnt == FULL) st <= S_PASS1;
        S_PASS1: st <= S_PASS2;
        S_PASS2: st <= S_OUT;
        S_OUT: begin
          if (out_ready_i) begin
            if (ocnt == LAST) begin
              ocnt <= '0;
              ccnt <= '0;
              pcnt <= '0;
              if (pair_q && !blk_q) begin
                st <= S_BLK2;
              end else begin
                st    <= S_IDLE;
                blk_q <= 1'b0;
              end
            end else begin
              ocnt <= ocnt + IDX_W'(1);
            end
          end
        end
        S_BLK2: begin
          blk_q <= 1'b1;
          st    <= S_LOAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: no load beat is taken while a block is being transformed or drained
  p_loads_closed_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_PASS1 || st == S_PASS2 || st == S_OUT || st == S_BLK2)
      |-> (!coef_ready_o && !pred_ready_o));

  // R1: load counters never exceed one block
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    (ccnt <= FULL) && (pcnt <= FULL));

  // R7: a stalled output row keeps its row index and block tag
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(ocnt) && $stable(blk_q)));

  // R8: the right-hand block tag only appears in pair mode
  p_blk_needs_pair_r8: assert property (@(posedge clk) disable iff (rst)
    blk_q |-> pair_q);

  // R9: passes run back to back into the output phase
  p_pass_seq_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_PASS1) |=> (st == S_PASS2));
  p_out_seq_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_PASS2) |=> (st == S_OUT));
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon import idct4_pkg::*; #(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pair_i,
  input  logic               coef_valid_i,
  output logic               coef_ready_o,
  input  logic [N*COEF_W-1:0] coef_row_i,
  input  logic               pred_valid_i,
  output logic               pred_ready_o,
  input  logic [N*PIX_W-1:0]  pred_row_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [N*PIX_W-1:0]  out_row_o,
  output logic               out_blk_o
);
  localparam int IDX_W = $clog2(N);

  logic signed [COEF_W-1:0] cf  [N][N];   // [row][col] coefficients
  logic signed [COEF_W-1:0] tmp [N][N];   // transposed first-pass result
  logic        [PIX_W-1:0]  pd  [N][N];   // prediction
  logic        [PIX_W-1:0]  rs  [N][N];   // reconstructed block
  logic signed [COEF_W-1:0] p1o [N][N];   // [col][k] first-pass outputs
  logic signed [COEF_W-1:0] p2o [N][N];   // [row][col] second-pass outputs
  logic        [PIX_W-1:0]  px  [N][N];

  logic             coef_we, pred_we, pass1, pass2;
  logic [IDX_W-1:0] coef_idx, pred_idx, out_idx;

  idct4_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .pair_i       (pair_i),
    .coef_valid_i (coef_valid_i),
    .pred_valid_i (pred_valid_i),
    .out_ready_i  (out_ready_i),
    .coef_ready_o (coef_ready_o),
    .pred_ready_o (pred_ready_o),
    .coef_we_o    (coef_we),
    .pred_we_o    (pred_we),
    .coef_idx_o   (coef_idx),
    .pred_idx_o   (pred_idx),
    .out_idx_o    (out_idx),
    .pass1_o      (pass1),
    .pass2_o      (pass2),
    .out_valid_o  (out_valid_o),
    .blk_o        (out_blk_o)
  );

  always_ff @(posedge clk) begin
    if (coef_we)
      for (int j = 0; j < N; j++) cf[coef_idx][j] <= coef_row_i[j*COEF_W +: COEF_W];
    if (pred_we)
      for (int j = 0; j < N; j++) pd[pred_idx][j] <= pred_row_i[j*PIX_W +: PIX_W];
    if (pass1)
      for (int k = 0; k < N; k++)
        for (int c = 0; c < N; c++) tmp[k][c] <= p1o[c][k];   // R4 transpose
    if (pass2)
      for (int r = 0; r < N; r++)
        for (int j = 0; j < N; j++) rs[r][j] <= px[r][j];
  end

  // R4: first pass down each column
  for (genvar c = 0; c < N; c++) begin : g_col
    idct4_bfly #(.W(COEF_W)) u_bfly (
      .i0 (cf[0][c]), .i1 (cf[1][c]), .i2 (cf[2][c]), .i3 (cf[3][c]),
      .o0 (p1o[c][0]), .o1 (p1o[c][1]), .o2 (p1o[c][2]), .o3 (p1o[c][3])
    );
  end

  // R4: second pass along each row, then round, add and clamp per pixel
  for (genvar r = 0; r < N; r++) begin : g_row
    idct4_bfly #(.W(COEF_W)) u_bfly (
      .i0 (tmp[r][0]), .i1 (tmp[r][1]), .i2 (tmp[r][2]), .i3 (tmp[r][3]),
      .o0 (p2o[r][0]), .o1 (p2o[r][1]), .o2 (p2o[r][2]), .o3 (p2o[r][3])
    );
    for (genvar j = 0; j < N; j++) begin : g_lane
      idct4_recon_lane #(.W(COEF_W), .P(PIX_W)) u_lane (
        .v    (p2o[r][j]),
        .pred (pd[r][j]),
        .pix  (px[r][j])
      );
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) out_row_o[j*PIX_W +: PIX_W] = rs[out_idx][j];
  end
endmodule

// File: tb/idct4_recon_test.sv
module idct4_recon_test;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int N  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            pair_i = 1'b0;
  logic            coef_valid = 1'b0, coef_ready;
  logic [N*CW-1:0] coef_row = '0;
  logic            pred_valid = 1'b0, pred_ready;
  logic [N*PW-1:0] pred_row = '0;
  logic            out_valid, out_blk;
  logic            out_ready = 1'b1;
  logic [N*PW-1:0] out_row;

  idct4_recon #(.COEF_W(CW), .PIX_W(PW)) uut (
    .clk (clk), .rst (rst), .pair_i (pair_i),
    .coef_valid_i (coef_valid), .coef_ready_o (coef_ready), .coef_row_i (coef_row),
    .pred_valid_i (pred_valid), .pred_ready_o (pred_ready), .pred_row_i (pred_row),
    .out_valid_o (out_valid), .out_ready_i (out_ready), .out_row_o (out_row),
    .out_blk_o (out_blk)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit bp = 1'b0;
  int cfa [32];
  int pda [32];
  logic [N*PW-1:0] exp_row [$];
  logic            exp_blk [$];
  string           exp_tag [$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // ---------------- integer reference model ----------------
  function automatic int s16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic int m1(int x);
    return s16(x + ((x * 20091) >>> 16));
  endfunction
  function automatic int m2(int x);
    return (x * 35468) >>> 16;
  endfunction
  task automatic bfly(input int x0, x4, x8, x12, output int y0, y1, y2, y3);
    int a, b, c, d;
    a = s16(x0 + x8);
    b = s16(x0 - x8);
    c = s16(m2(x4) - m1(x12));
    d = s16(m1(x4) + m2(x12));
    y0 = s16(a + d); y1 = s16(b + c); y2 = s16(b - c); y3 = s16(a - d);
  endtask

  task automatic model_block(int base, bit blk, string tag);
    int t [4][4];
    int y [4];
    int v, s;
    logic [N*PW-1:0] row;
    for (int c = 0; c < 4; c++) begin
      bfly(cfa[base+c], cfa[base+4+c], cfa[base+8+c], cfa[base+12+c], y[0], y[1], y[2], y[3]);
      for (int k = 0; k < 4; k++) t[k][c] = y[k];
    end
    for (int r = 0; r < 4; r++) begin
      bfly(t[r][0], t[r][1], t[r][2], t[r][3], y[0], y[1], y[2], y[3]);
      for (int j = 0; j < 4; j++) begin
        v = (y[j] + 4) >>> 3;
        s = v + pda[base + r*4 + j];
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        row[j*PW +: PW] = PW'(s);
      end
      exp_row.push_back(row);
      exp_blk.push_back(blk);
      exp_tag.push_back(tag);
    end
  endtask

  // ---------------- drivers ----------------
  task automatic send_coefs(int nrows, bit pair);
    for (int r = 0; r < nrows; r++) begin
      logic acc;
      for (int j = 0; j < N; j++) coef_row[j*CW +: CW] = CW'(cfa[r*4 + j]);
      pair_i     = (r == 0) ? pair : 1'b0;   // later beats must not matter (R8)
      coef_valid = 1'b1;
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk); acc = coef_ready;
        @(posedge clk); #1;
      end
    end
    coef_valid = 1'b0;
  endtask

  task automatic send_preds(int nrows);
    for (int r = 0; r < nrows; r++) begin
      logic acc;
      for (int j = 0; j < N; j++) pred_row[j*PW +: PW] = PW'(pda[r*4 + j]);
      pred_valid = 1'b1;
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk); acc = pred_ready;
        @(posedge clk); #1;
      end
    end
    pred_valid = 1'b0;
  endtask

  task automatic run(int nb, bit pair, string tag);
    model_block(0, 1'b0, tag);
    if (nb == 2) model_block(16, 1'b1, tag);
    fork
      send_coefs(nb*4, pair);
      send_preds(nb*4);
    join
  endtask

  task automatic drain();
    while (exp_row.size() != 0) @(negedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  function automatic int rnd_s(int m);
    return int'($urandom_range(0, 2*m)) - m;
  endfunction
  task automatic fill(int base, int m, int pmin, int pmax);
    for (int i = 0; i < 16; i++) begin
      cfa[base+i] = rnd_s(m);
      pda[base+i] = int'($urandom_range(pmin, pmax));
    end
  endtask
  task automatic fill_ext(int base);
    for (int i = 0; i < 16; i++) begin
      case ($urandom_range(0, 3))
        0: cfa[base+i] = 32767;
        1: cfa[base+i] = -32768;
        2: cfa[base+i] = 0;
        default: cfa[base+i] = rnd_s(32767);
      endcase
      pda[base+i] = int'($urandom_range(0, 255));
    end
  endtask

  // ---------------- output monitor ----------------
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_row.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected row act=%0h exp=none", out_row);
      end else begin
        chk(exp_tag.pop_front(), 64'({out_blk, out_row}),
            64'({exp_blk.pop_front(), exp_row.pop_front()}));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp ? ($urandom_range(0, 1) == 1) : 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 valid low in reset", 64'(out_valid), 64'(0));
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", 64'({coef_ready, pred_ready}), 64'(2'b11));
    @(posedge clk); #1;

    // R6: zero coefficients return the prediction
    fill(0, 0, 0, 255);
    run(1, 1'b0, "R6 zero residual");
    drain();

    // R3/R5: DC-only blocks, both signs
    fill(0, 0, 0, 255); cfa[0] = 100;
    run(1, 1'b0, "R5 dc positive");
    drain();
    fill(0, 0, 0, 255); cfa[0] = -77;
    run(1, 1'b0, "R5 dc negative");
    drain();

    // R4: single non-DC coefficients exercise each multiplier path
    for (int k = 1; k < 16; k += 3) begin
      fill(0, 0, 60, 190); cfa[k] = 1000 - 150*k;
      run(1, 1'b0, "R4 single coefficient");
      drain();
    end

    // R3/R4: random moderate blocks
    for (int i = 0; i < 10; i++) begin
      fill(0, 2000, 0, 255);
      run(1, 1'b0, "R3 random block");
      drain();
    end

    // R3: extreme coefficients drive every saturation point
    for (int i = 0; i < 8; i++) begin
      fill_ext(0);
      run(1, 1'b0, "R3 extreme block");
      drain();
    end

    // R6: clip high and clip low
    fill(0, 0, 240, 255); cfa[0] = 32767;
    run(1, 1'b0, "R6 clip high");
    drain();
    fill(0, 0, 0, 15); cfa[0] = -32768;
    run(1, 1'b0, "R6 clip low");
    drain();

    // R9/R1: latency from last load beat and closed load ports
    fill(0, 3000, 0, 255);
    run(1, 1'b0, "R9 latency block");
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      if (n < 4) begin
        chk("R9 valid still low", 64'(out_valid), 64'(0));
        chk("R1 loads closed", 64'({coef_ready, pred_ready}), 64'(0));
      end else begin
        chk("R9 valid after three edges", 64'(out_valid), 64'(1));
      end
    end
    drain();

    // R2: all prediction rows before any coefficient row
    fill(0, 1500, 0, 255);
    model_block(0, 1'b0, "R2 prediction first");
    send_preds(4);
    send_coefs(4, 1'b0);
    drain();

    // R7: random backpressure on single blocks
    bp = 1'b1;
    for (int i = 0; i < 4; i++) begin
      fill(0, 4000, 0, 255);
      run(1, 1'b0, "R7 backpressure");
      drain();
    end

    // R8: pair mode, with and without backpressure
    for (int i = 0; i < 4; i++) begin
      bp = (i % 2 == 1);
      fill(0, 2500, 0, 255);
      fill(16, 2500, 0, 255);
      if (i == 3) fill_ext(16);
      run(2, 1'b1, "R8 pair mode");
      drain();
    end
    bp = 1'b0;

    // R8: a single block after pair mode is tagged as the first block
    fill(0, 800, 0, 255);
    run(1, 1'b0, "R8 single after pair");
    drain();
    @(negedge clk);
    chk("R8 idle after single", 64'({out_valid, coef_ready, pred_ready}), 64'(3'b011));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule